// File: doc/BRIEF.md
# GPIO Interrupt Unit with Per-Pin Triggers

This block is a 32-pin general-purpose I/O unit behind a 16-bit register bus. Each pin has a two-bit mode field that selects its direction and whether it is handed to an alternate function. The pins' data is read and written as two 16-bit halves. A pin in input mode reads back its synchronized input level. A pin in output mode reads back the value it drives.

The lower sixteen pins can each raise an interrupt. Each of these pins has a trigger type (high level, low level, rising edge or falling edge), an enable bit, a mask bit and a sticky status bit. The enable decides whether a trigger is latched into status at all. The mask decides only whether a latched status reaches the single registered interrupt line. The host services an interrupt by reading the status word and writing the same value back, which clears every bit it saw.

The bus write is a one-cycle strobe with address and data. Reads are combinational from the address and have no side effect.

Top module: `gpio_irq_unit`

## Requirements
- R1: After a synchronous reset every register reads 0 and `pin_out`, `pin_oe`, `pin_alt` and `irq` are all 0, so every pin is a GPIO input with no interrupt enabled or masked.
- R2: Address 0 holds pins 0–15 and address 1 holds pins 16–31, with pin n at bit n mod 16. A write sets the output latches, which drive `pin_out`. A read returns the latch for an output-mode pin and, for an input-mode pin, the input level as seen two clock edges after it changes.
- R3: Pin n has a mode field at address 2 + n/8, bits 2*(n mod 8)+1 : 2*(n mod 8). Field bit 0 set makes the pin an output (`pin_oe`). Field bit 1 set hands the pin to its alternate function (`pin_alt`).
- R4: Trigger types for pins 0–7 are at address 7 and for pins 8–15 at address 6, each in a field at bits 2*(n mod 8)+1 : 2*(n mod 8). The field encodes 00 = high level, 01 = low level, 10 = rising edge, 11 = falling edge.
- R5: A level-type status bit is set while its enabled level condition holds. A write-one-to-clear during that time leaves it reading 1.
- R6: An edge on an enabled edge-type pin sets its status bit three clock edges after the input changes, and only once per edge. After a clear, the bit stays 0 until a new edge of the selected polarity arrives.
- R7: The enable register is at address 8. A pin whose enable bit is 0 never latches status, whatever its input does.
- R8: The mask register is at address 9. A mask bit of 1 keeps that pin's status from reaching `irq`, while the status stays readable.
- R9: The status register is at address 10. Writing 1 to a bit clears it and writing 0 leaves it unchanged, so writing back a value just read clears exactly the pending bits.
- R10: `irq` is registered. It rises one clock edge after any unmasked status bit is set, and falls one edge after the last unmasked status bit is cleared or masked.
- R11: When an edge event and a write-one-to-clear hit the same status bit at the same clock edge, the bit stays set.
- R12: Pins 16–31 never set any status bit; status bits 15:0 belong only to pins 15:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| pin_in | input | 32 | Asynchronous pin input levels |
| pin_out | output | 32 | Output latch values |
| pin_oe | output | 32 | Per-pin output enable |
| pin_alt | output | 32 | Per-pin alternate-function select |
| irq | output | 1 | Combined interrupt to the host |

## Verification
A status bit latched wrongly shows up at the status address as soon as it is read, and on `irq` one edge later unless the bit is masked. This makes stuck, lost or doubled events visible within four edges of a pin change. A trigger-type word decoded at the wrong address turns a pin into a level trigger and sets status where none is due. A wrong clear-versus-event priority shows up as a zero status immediately after a collision that should have left the bit set. Mis-steered mode or data bits appear at once on `pin_oe`, `pin_alt` or `pin_out`, or in the data readback two edges after an input change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int NUM_PINS      = 32;
    localparam int NUM_IRQ       = 16;
    localparam int BUS_W         = 16;
    localparam int ADDR_W        = 4;
    localparam int MODE_W        = 2;
    localparam int PINS_PER_WORD = BUS_W / MODE_W;
    localparam int NUM_MODE_REGS = NUM_PINS / PINS_PER_WORD;
    localparam int NUM_DATA_REGS = NUM_PINS / BUS_W;

    // Register word addresses
    localparam logic [ADDR_W-1:0] A_DATA0   = 4'd0;
    localparam logic [ADDR_W-1:0] A_MODE0   = 4'd2;
    localparam logic [ADDR_W-1:0] A_TYPE_HI = 4'd6;   // pins 8..15
    localparam logic [ADDR_W-1:0] A_TYPE_LO = 4'd7;   // pins 0..7
    localparam logic [ADDR_W-1:0] A_ENABLE  = 4'd8;
    localparam logic [ADDR_W-1:0] A_MASK    = 4'd9;
    localparam logic [ADDR_W-1:0] A_STATUS  = 4'd10;

    typedef enum logic [1:0] {
        TRIG_HIGH = 2'b00,
        TRIG_LOW  = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;

    typedef struct packed {
        logic cur;
        logic prev;
    } samp_t;

    typedef struct packed {
        logic alt;
        logic out;
    } mode_t;

    function automatic logic trig_hit(trig_e t, samp_t s);
        logic hit;
        case (t)
            TRIG_HIGH: hit = s.cur;
            TRIG_LOW:  hit = !s.cur;
            TRIG_RISE: hit = s.cur && !s.prev;
            default:   hit = !s.cur && s.prev;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W      = 32,
    parameter int HIST_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      async_i,
    output logic [W-1:0]      cur_o,
    output logic [HIST_W-1:0] prev_o
);
    logic [W-1:0]      meta_q;
    logic [W-1:0]      cur_q;
    logic [HIST_W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_i;
            cur_q  <= meta_q;
            prev_q <= cur_q[HIST_W-1:0];
        end
    end

    assign cur_o  = cur_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_irq_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 wr_i,
    input  logic [ADDR_W-1:0]                    addr_i,
    input  logic [BUS_W-1:0]                     wdata_i,
    output logic [NUM_DATA_REGS-1:0][BUS_W-1:0]  data_o,
    output logic [NUM_MODE_REGS-1:0][BUS_W-1:0]  mode_o,
    output logic [BUS_W-1:0]                     type_hi_o,
    output logic [BUS_W-1:0]                     type_lo_o,
    output logic [NUM_IRQ-1:0]                   enable_o,
    output logic [NUM_IRQ-1:0]                   mask_o
);
    logic [NUM_DATA_REGS-1:0][BUS_W-1:0] data_q;
    logic [NUM_MODE_REGS-1:0][BUS_W-1:0] mode_q;
    logic [BUS_W-1:0]                    type_hi_q, type_lo_q;
    logic [NUM_IRQ-1:0]                  enable_q, mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q    <= '0;
            mode_q    <= '0;
            type_hi_q <= '0;
            type_lo_q <= '0;
            enable_q  <= '0;
            mask_q    <= '0;
        end else if (wr_i) begin
            for (int k = 0; k < NUM_DATA_REGS; k++)
                if (addr_i == A_DATA0 + ADDR_W'(k)) data_q[k] <= wdata_i;
            for (int k = 0; k < NUM_MODE_REGS; k++)
                if (addr_i == A_MODE0 + ADDR_W'(k)) mode_q[k] <= wdata_i;
            if (addr_i == A_TYPE_HI) type_hi_q <= wdata_i;
            if (addr_i == A_TYPE_LO) type_lo_q <= wdata_i;
            if (addr_i == A_ENABLE)  enable_q  <= wdata_i[NUM_IRQ-1:0];
            if (addr_i == A_MASK)    mask_q    <= wdata_i[NUM_IRQ-1:0];
        end
    end

    assign data_o    = data_q;
    assign mode_o    = mode_q;
    assign type_hi_o = type_hi_q;
    assign type_lo_o = type_lo_q;
    assign enable_o  = enable_q;
    assign mask_o    = mask_q;

    // R8
    mask_load_chk: assert property (@(posedge clk) disable iff (rst)
        $past(wr_i && addr_i == A_MASK) |-> mask_q == $past(wdata_i[NUM_IRQ-1:0]));
endmodule

// File: rtl/gpio_trig_cell.sv
module gpio_trig_cell
    import gpio_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en_i,
    input  trig_e type_i,
    input  samp_t samp_i,
    input  logic  clr_i,
    output logic  status_o
);
    logic status_q;
    logic det_w;

    assign det_w = en_i && trig_hit(type_i, samp_i);

    always_ff @(posedge clk) begin
        if (rst) status_q <= 1'b0;
        else     status_q <= det_w || (status_q && !clr_i);
    end

    assign status_o = status_q;

    // R7
    status_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status_q) |-> $past(en_i));
    // R9
    clear_takes_effect_chk: assert property (@(posedge clk) disable iff (rst)
        $past(clr_i && !det_w) |-> !status_q);
    // R11
    event_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(clr_i && det_w) |-> status_q);
    // R6
    rise_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(status_q) && $past(type_i == TRIG_RISE)) |-> $past(samp_i.cur && !samp_i.prev));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_alt,
    output logic                irq
);
    logic [NUM_PINS-1:0]                 cur_w;
    logic [NUM_IRQ-1:0]                  prev_w;
    logic [NUM_DATA_REGS-1:0][BUS_W-1:0] data_w;
    logic [NUM_MODE_REGS-1:0][BUS_W-1:0] mode_w;
    logic [BUS_W-1:0]                    type_hi_w, type_lo_w;
    logic [NUM_IRQ-1:0]                  enable_w, mask_w;
    logic [NUM_IRQ-1:0]                  status_w, clr_w, pend_w;
    logic [NUM_PINS-1:0]                 view_w;
    logic                                irq_q;

    gpio_pin_sync #(.W(NUM_PINS), .HIST_W(NUM_IRQ)) i_sync (
        .clk(clk), .rst(rst), .async_i(pin_in), .cur_o(cur_w), .prev_o(prev_w)
    );

    gpio_cfg_regs i_regs (
        .clk(clk), .rst(rst), .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
        .data_o(data_w), .mode_o(mode_w), .type_hi_o(type_hi_w), .type_lo_o(type_lo_w),
        .enable_o(enable_w), .mask_o(mask_w)
    );

    // Per-pin mode decode and data readback view
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        localparam int WORD = n / PINS_PER_WORD;
        localparam int SLOT = n % PINS_PER_WORD;
        mode_t mode;
        assign mode       = mode_t'(mode_w[WORD][MODE_W*SLOT +: MODE_W]);
        assign pin_oe[n]  = mode.out;
        assign pin_alt[n] = mode.alt;
        assign pin_out[n] = data_w[n / BUS_W][n % BUS_W];
        assign view_w[n]  = mode.out ? pin_out[n] : cur_w[n];
    end

    // Interrupt lines: pins 0..7 use the type word at the higher address
    assign clr_w = (bus_wr && bus_addr == A_STATUS) ? bus_wdata[NUM_IRQ-1:0] : '0;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        localparam int SLOT = i % PINS_PER_WORD;
        trig_e tsel;
        samp_t samp;
        if (i < PINS_PER_WORD) begin : g_lo
            assign tsel = trig_e'(type_lo_w[MODE_W*SLOT +: MODE_W]);
        end else begin : g_hi
            assign tsel = trig_e'(type_hi_w[MODE_W*SLOT +: MODE_W]);
        end
        assign samp.cur  = cur_w[i];
        assign samp.prev = prev_w[i];
        gpio_trig_cell i_cell (
            .clk(clk), .rst(rst), .en_i(enable_w[i]), .type_i(tsel),
            .samp_i(samp), .clr_i(clr_w[i]), .status_o(status_w[i])
        );
    end

    assign pend_w = status_w & ~mask_w;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |pend_w;
    end
    assign irq = irq_q;

    // Register read mux
    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NUM_DATA_REGS; k++)
            if (bus_addr == A_DATA0 + ADDR_W'(k)) bus_rdata = view_w[k*BUS_W +: BUS_W];
        for (int k = 0; k < NUM_MODE_REGS; k++)
            if (bus_addr == A_MODE0 + ADDR_W'(k)) bus_rdata = mode_w[k];
        if (bus_addr == A_TYPE_HI) bus_rdata = type_hi_w;
        if (bus_addr == A_TYPE_LO) bus_rdata = type_lo_w;
        if (bus_addr == A_ENABLE)  bus_rdata = BUS_W'(enable_w);
        if (bus_addr == A_MASK)    bus_rdata = BUS_W'(mask_w);
        if (bus_addr == A_STATUS)  bus_rdata = BUS_W'(status_w);
    end

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(pend_w == '0) |-> !irq);
    // R10
    irq_follows_chk: assert property (@(posedge clk) disable iff (rst)
        $past(pend_w != '0) |-> irq);
endmodule

// File: tb/test_gpio_irq_unit.sv
module test_gpio_irq_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe, pin_alt;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    gpio_irq_unit i_gpio_irq_unit (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_alt(pin_alt), .irq(irq)
    );

    task automatic tick(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #5;
        end
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk_reg(string req, logic [3:0] a, logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(req, $sformatf("reg %0d", a), {16'h0, v}, {16'h0, exp});
    endtask

    task automatic do_reset();
        pin_in = '0;
        bus_wr = 1'b0;
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick();
    endtask

    task automatic t_reset();
        do_reset();
        pin_in = 32'hFFFF_FFFF;
        rst = 1'b1;
        tick(3);
        for (int a = 0; a < 11; a++) chk_reg("R1", 4'(a), 16'h0);
        chk("R1", "pin_out", pin_out, 0);
        chk("R1", "pin_oe", pin_oe, 0);
        chk("R1", "pin_alt", pin_alt, 0);
        chk("R1", "irq", {31'h0, irq}, 0);
        rst = 1'b0;
    endtask

    task automatic t_data();
        do_reset();
        wr(4'd2, 16'h0040);            // pin 3 output
        wr(4'd0, 16'h0008);
        chk("R2", "pin_out", pin_out, 32'h0000_0008);
        chk("R3", "pin_oe", pin_oe, 32'h0000_0008);
        pin_in[7] = 1'b1;
        tick(2);
        chk_reg("R2", 4'd0, 16'h0088);
        pin_in[31:16] = 16'hA5A5;
        tick(2);
        chk_reg("R2", 4'd1, 16'hA5A5);
        wr(4'd4, 16'h0200);            // pin 20 alternate input
        chk("R3", "pin_alt", pin_alt, 32'h0010_0000);
        chk("R3", "pin_oe", pin_oe, 32'h0000_0008);
        wr(4'd8, 16'hFF7F);            // all lines but pin 7 (high, level)
        tick(3);
        chk_reg("R12", 4'd10, 16'h0000);
    endtask

    task automatic t_order_edge();
        do_reset();
        wr(4'd7, 16'h0020);            // pin 2 rising
        wr(4'd6, 16'h000C);            // pin 9 falling
        wr(4'd8, 16'h0204);
        pin_in[9] = 1'b1;
        tick(3);
        chk_reg("R4", 4'd10, 16'h0000);
        pin_in[2] = 1'b1;
        tick(2);
        chk_reg("R6", 4'd10, 16'h0000);
        tick();
        chk_reg("R6", 4'd10, 16'h0004);
        chk("R10", "irq early", {31'h0, irq}, 0);
        tick();
        chk("R10", "irq", {31'h0, irq}, 1);
        tick(5);
        wr(4'd10, 16'h0004);
        chk_reg("R9", 4'd10, 16'h0000);
        tick(4);
        chk_reg("R6", 4'd10, 16'h0000);
        pin_in[9] = 1'b0;
        tick(3);
        chk_reg("R6", 4'd10, 16'h0200);
        // collision: new falling edge and clear on the same edge
        pin_in[9] = 1'b1;
        tick(3);
        pin_in[9] = 1'b0;
        tick(2);
        wr(4'd10, 16'h0200);
        chk_reg("R11", 4'd10, 16'h0200);
        wr(4'd10, 16'h0200);
        chk_reg("R11", 4'd10, 16'h0000);
    endtask

    task automatic t_level();
        do_reset();
        wr(4'd6, 16'h0100);            // pin 12 low level
        wr(4'd8, 16'h1020);            // pins 5 and 12
        tick();
        chk_reg("R5", 4'd10, 16'h1000);
        wr(4'd10, 16'h1000);
        chk_reg("R5", 4'd10, 16'h1000);
        pin_in[12] = 1'b1;
        tick(3);
        chk_reg("R5", 4'd10, 16'h1000);
        wr(4'd10, 16'h1000);
        tick();
        chk_reg("R5", 4'd10, 16'h0000);
        pin_in[5] = 1'b1;
        tick(3);
        chk_reg("R5", 4'd10, 16'h0020);
        wr(4'd10, 16'h0020);
        chk_reg("R5", 4'd10, 16'h0020);
    endtask

    task automatic t_enable();
        do_reset();
        wr(4'd7, 16'h0020);
        pin_in[2] = 1'b1;
        tick(4);
        chk_reg("R7", 4'd10, 16'h0000);
        chk("R7", "irq", {31'h0, irq}, 0);
    endtask

    task automatic t_mask_ack();
        logic [15:0] v;
        do_reset();
        wr(4'd7, 16'h0020);
        wr(4'd6, 16'h000C);
        wr(4'd9, 16'h0204);
        wr(4'd8, 16'h0204);
        pin_in[9] = 1'b1;
        tick(3);
        pin_in[2] = 1'b1;
        pin_in[9] = 1'b0;
        tick(4);
        chk_reg("R8", 4'd10, 16'h0204);
        chk("R8", "irq masked", {31'h0, irq}, 0);
        wr(4'd9, 16'h0000);
        chk("R10", "irq after unmask", {31'h0, irq}, 0);
        tick();
        chk("R10", "irq unmasked", {31'h0, irq}, 1);
        wr(4'd10, 16'h0004);
        chk_reg("R9", 4'd10, 16'h0200);
        rd(4'd10, v);
        wr(4'd10, v);
        chk_reg("R9", 4'd10, 16'h0000);
        chk("R10", "irq holds one edge", {31'h0, irq}, 1);
        tick();
        chk("R10", "irq falls", {31'h0, irq}, 0);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick();
        t_reset();
        t_data();
        t_order_edge();
        t_level();
        t_enable();
        t_mask_ack();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule